// File: doc/BRIEF.md
# Translation Lookaside Buffer

This block is a small fully associative cache of recent address translations. A lookup presents a segment number, a virtual page number, a page offset and the access kind (read or write). The segment and virtual page number together form the tag, and all stored tags are compared in parallel. When a valid entry matches and its cached permission bits allow the access, the block signals a hit. In the same cycle it drives the physical address, which is the cached physical page number with the page offset appended.

When no valid entry matches, the block raises a miss. The surrounding logic then walks the segment and page tables and returns the translation through the fill port. A fill goes to the lowest-numbered empty entry if one exists. Otherwise it replaces the entry under a round-robin pointer. A fill whose tag is already present rewrites that entry in place. A flush input empties the whole buffer in one cycle, which is meant for a context switch.

A matching entry whose permission bits forbid the access reports a protection fault instead of a hit or a miss. The entry count is a parameter, legal from 64 to 2048.

Top module: `xlat_cache`

## Requirements
- R1: The tag is the segment number together with the virtual page number. A lookup matches only a valid entry whose segment and virtual page number are both equal to the request, so the same virtual page under a different segment misses.
- R2: On a hit, `lk_paddr` equals the entry's physical page number in the upper bits with `lk_off` in the low `OFF_W` bits, in the same cycle as the request. Whenever `lk_hit` is low, `lk_paddr` is zero.
- R3: A valid lookup with no matching valid entry raises `lk_miss` and nothing else. A fill is visible to lookups from the cycle after it is accepted.
- R4: While any entry is invalid, a fill of a new tag goes to the lowest-numbered invalid entry, and no valid entry is displaced.
- R5: The round-robin pointer starts at entry 0 after reset. It advances by one, wrapping at `ENTRIES`, on every fill that creates a new entry, and a flush leaves it unchanged. When all entries are valid, a new fill replaces the entry at the pointer.
- R6: A fill whose tag equals a valid entry's tag overwrites that entry's page number and permissions in place. It creates no duplicate and does not move the pointer.
- R7: Each entry caches a read bit and a write bit. A matching lookup with `lk_write`=0 needs the read bit, and one with `lk_write`=1 needs the write bit. A violation raises `lk_fault` only, with `lk_hit` and `lk_miss` low and `lk_paddr` zero.
- R8: Asserting `flush` invalidates every entry at the next clock edge. A fill presented in the same cycle as a flush is discarded.
- R9: After reset all entries are invalid, so every lookup misses.
- R10: With `lk_valid` low, `lk_hit`, `lk_miss` and `lk_fault` are all low, whatever the other lookup inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Invalidate all entries at the next edge |
| lk_valid | input | 1 | Lookup request present |
| lk_seg | input | SEG_W | Lookup segment number |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_off | input | OFF_W | Lookup page offset |
| lk_write | input | 1 | Access kind: 1 write, 0 read |
| lk_hit | output | 1 | Translation found and permitted |
| lk_miss | output | 1 | No valid entry matches; a table walk is needed |
| lk_fault | output | 1 | Entry found but the access is not permitted |
| lk_paddr | output | PPN_W+OFF_W | Physical address on hit, zero otherwise |
| fl_valid | input | 1 | Fill request present |
| fl_seg | input | SEG_W | Fill segment number |
| fl_vpn | input | VPN_W | Fill virtual page number |
| fl_ppn | input | PPN_W | Fill physical page number |
| fl_rd | input | 1 | Fill read permission |
| fl_wr | input | 1 | Fill write permission |

## Verification
On every cycle the assertions check the following:
- hit, miss and fault are mutually exclusive and are silent without a request;
- the offset passes through on a hit;
- no tag appears twice;
- an accepted fill leaves its entry valid, and an in-place fill keeps the valid count;
- the chosen victim is empty while any entry is empty;
- the pointer steps by exactly one per new entry;
- a flush empties the buffer.

Which entry is evicted, and in which order, can only be shown by the bench's scenarios. The bench fills the buffer completely, overflows it, rewrites entries in place, and flushes while a fill is pending. It then sweeps lookups across every tag and compares each result against an arithmetic model.

// File: rtl/xlat_pkg.sv
// Shared types for the translation cache.
// Assumes: nothing beyond IEEE 1800-2017 packed types.
package xlat_pkg;

    // Cached access rights of one translation.
    typedef struct packed {
        logic rd;
        logic wr;
    } xlat_perm_t;

endpackage

// File: rtl/xlat_cam.sv
// Parallel tag comparator for the translation cache.
// Compares one key with every stored tag, masked by the valid bits, and
// returns the match vector, an any-match flag and the encoded index.
// Assumes: at most one entry matches (the parent never stores duplicates),
// so the index is formed by OR-ing the indices of matching entries.
module xlat_cam #(
    parameter int N     = 64,
    parameter int KEY_W = 12,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     valid,
    input  logic [KEY_W-1:0] tags [N],
    input  logic [KEY_W-1:0] key,
    output logic [N-1:0]     match,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    // One comparator per entry.
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = valid[g] && (tags[g] == key);
    end

    // Any-match reduction.
    assign any = |match;

    // Encode the matching entry's position.
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) idx = idx | IDX_W'(i);
        end
    end

endmodule

// File: rtl/xlat_victim.sv
// Replacement selector for the translation cache.
// Picks the lowest-numbered invalid entry if one exists, or else the entry
// under a round-robin pointer. The pointer steps once per new-entry fill.
// Assumes: `advance` is raised only in cycles where the victim is written.
module xlat_victim #(
    parameter int N = 64,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     valid,
    input  logic             advance,
    output logic [IDX_W-1:0] victim
);

    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] free_idx;
    logic             free_any;

    // Lowest-numbered empty slot (scan from the top so the lowest wins).
    always_comb begin
        free_idx = '0;
        free_any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                free_idx = IDX_W'(i);
                free_any = 1'b1;
            end
        end
    end

    // Empty slots take precedence over the pointer.
    assign victim = free_any ? free_idx : ptr_q;

    // Round-robin pointer, wrapping at N.
    always_ff @(posedge clk) begin
        if (!rst_n)            ptr_q <= '0;
        else if (advance)      ptr_q <= (ptr_q == IDX_W'(N - 1)) ? '0 : ptr_q + 1'b1;
    end

    // R4
    victim_empty_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(&valid) |-> !valid[victim]);

    // R5
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> ptr_q == (($past(ptr_q) == IDX_W'(N - 1)) ? '0 : $past(ptr_q) + 1'b1));

    // R5
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(ptr_q));

endmodule

// File: rtl/xlat_cache.sv
// Fully associative translation lookaside buffer.
// A lookup is combinational: tag = {segment, virtual page}; a permitted match
// yields {ppn, offset} in the same cycle, a forbidden one a fault, no match
// a miss. Fills write at the clock edge, either in place (tag present), into
// the lowest empty entry, or over the round-robin victim. Flush clears all
// valid bits and overrides a concurrent fill.
// Assumes: ENTRIES in 64..2048; the external walker presents one fill per
// cycle at most.
module xlat_cache #(
    parameter int ENTRIES = 64,
    parameter int SEG_W   = 4,
    parameter int VPN_W   = 8,
    parameter int PPN_W   = 12,
    parameter int OFF_W   = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush,
    input  logic                   lk_valid,
    input  logic [SEG_W-1:0]       lk_seg,
    input  logic [VPN_W-1:0]       lk_vpn,
    input  logic [OFF_W-1:0]       lk_off,
    input  logic                   lk_write,
    output logic                   lk_hit,
    output logic                   lk_miss,
    output logic                   lk_fault,
    output logic [PPN_W+OFF_W-1:0] lk_paddr,
    input  logic                   fl_valid,
    input  logic [SEG_W-1:0]       fl_seg,
    input  logic [VPN_W-1:0]       fl_vpn,
    input  logic [PPN_W-1:0]       fl_ppn,
    input  logic                   fl_rd,
    input  logic                   fl_wr
);
    import xlat_pkg::*;

    localparam int KEY_W = SEG_W + VPN_W;
    localparam int IDX_W = $clog2(ENTRIES);

    // configuration range
    initial begin
        entries_range_chk: assert (ENTRIES >= 64 && ENTRIES <= 2048);
    end

    logic [ENTRIES-1:0] valid_q;
    logic [KEY_W-1:0]   tag_q  [ENTRIES];
    logic [PPN_W-1:0]   ppn_q  [ENTRIES];
    xlat_perm_t         perm_q [ENTRIES];

    logic [KEY_W-1:0]   lk_key, fl_key;
    logic [ENTRIES-1:0] lk_match, fl_match;
    logic               lk_any, fl_any;
    logic [IDX_W-1:0]   lk_idx, fl_idx, victim, wr_idx;
    logic               allowed, fill_do, new_entry;
    xlat_perm_t         lk_perm;

    assign lk_key = {lk_seg, lk_vpn};
    assign fl_key = {fl_seg, fl_vpn};

    // Lookup-side comparator.
    xlat_cam #(.N(ENTRIES), .KEY_W(KEY_W)) u_lk_cam (
        .valid(valid_q), .tags(tag_q), .key(lk_key),
        .match(lk_match), .any(lk_any), .idx(lk_idx)
    );

    // Fill-side comparator, to find an existing copy of the fill tag.
    xlat_cam #(.N(ENTRIES), .KEY_W(KEY_W)) u_fl_cam (
        .valid(valid_q), .tags(tag_q), .key(fl_key),
        .match(fl_match), .any(fl_any), .idx(fl_idx)
    );

    // Replacement choice for new tags.
    xlat_victim #(.N(ENTRIES)) u_victim (
        .clk(clk), .rst_n(rst_n), .valid(valid_q),
        .advance(new_entry), .victim(victim)
    );

    // Permission check on the matching entry.
    always_comb begin
        lk_perm = perm_q[lk_idx];
        allowed = lk_write ? lk_perm.wr : lk_perm.rd;
    end

    // Lookup outcome and physical address.
    always_comb begin
        lk_hit   = lk_valid && lk_any && allowed;
        lk_fault = lk_valid && lk_any && !allowed;
        lk_miss  = lk_valid && !lk_any;
        lk_paddr = lk_hit ? {ppn_q[lk_idx], lk_off} : '0;
    end

    // Fill acceptance and destination.
    assign fill_do   = fl_valid && !flush;
    assign new_entry = fill_do && !fl_any;
    assign wr_idx    = fl_any ? fl_idx : victim;

    // Valid bits: reset and flush clear, fill sets.
    always_ff @(posedge clk) begin
        if (!rst_n)       valid_q <= '0;
        else if (flush)   valid_q <= '0;
        else if (fill_do) valid_q[wr_idx] <= 1'b1;
    end

    // Entry payload written on an accepted fill.
    always_ff @(posedge clk) begin
        if (fill_do) begin
            tag_q[wr_idx]  <= fl_key;
            ppn_q[wr_idx]  <= fl_ppn;
            perm_q[wr_idx] <= '{rd: fl_rd, wr: fl_wr};
        end
    end

    // R3
    outcome_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> $onehot({lk_hit, lk_miss, lk_fault}));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !(lk_hit || lk_miss || lk_fault));

    // R2
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_paddr[OFF_W-1:0] == lk_off);

    // R2
    paddr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> lk_paddr == '0);

    // R6
    no_dup_lk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));

    // R6
    no_dup_fl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fl_match));

    // R6
    inplace_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_do && fl_any) |=> $countones(valid_q) == $countones($past(valid_q)));

    // R3
    fill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_do |=> valid_q[$past(wr_idx)]);

    // R8
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> valid_q == '0);

endmodule

// File: tb/xlat_cache_tb.sv
// Self-checking bench: drives fills, flushes and lookup sweeps and compares
// every outcome against a behavioural model kept in the bench.
module xlat_cache_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        lk_valid = 1'b0;
    logic [3:0]  lk_seg = '0;
    logic [7:0]  lk_vpn = '0;
    logic [11:0] lk_off = '0;
    logic        lk_write = 1'b0;
    logic        lk_hit, lk_miss, lk_fault;
    logic [23:0] lk_paddr;
    logic        fl_valid = 1'b0;
    logic [3:0]  fl_seg = '0;
    logic [7:0]  fl_vpn = '0;
    logic [11:0] fl_ppn = '0;
    logic        fl_rd = 1'b0, fl_wr = 1'b0;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    // model state
    bit          m_v   [N];
    logic [11:0] m_key [N];
    logic [11:0] m_ppn [N];
    bit          m_rd  [N];
    bit          m_wr  [N];
    int          m_ptr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xlat_cache u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_valid(lk_valid), .lk_seg(lk_seg), .lk_vpn(lk_vpn), .lk_off(lk_off),
        .lk_write(lk_write), .lk_hit(lk_hit), .lk_miss(lk_miss),
        .lk_fault(lk_fault), .lk_paddr(lk_paddr),
        .fl_valid(fl_valid), .fl_seg(fl_seg), .fl_vpn(fl_vpn), .fl_ppn(fl_ppn),
        .fl_rd(fl_rd), .fl_wr(fl_wr)
    );

    function automatic logic [11:0] ppn_of(int t, int salt);
        return 12'(t * 29 + salt * 7 + 3);
    endfunction

    task automatic check(string req, logic [26:0] act, logic [26:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual hit/miss/fault/paddr=%h expected=%h", req, act, exp);
        end
    endtask

    // Lookup tag t (seg = t[3:0], vpn = t[11:4]) and compare with the model.
    task automatic look(int t, bit wr, string req);
        logic [11:0] k = 12'(t);
        logic [11:0] off = 12'(t * 61 + 17);
        logic [26:0] exp = {1'b0, 1'b1, 1'b0, 24'h0};
        @(negedge clk);
        lk_valid = 1'b1; lk_seg = k[3:0]; lk_vpn = k[11:4];
        lk_off = off; lk_write = wr;
        #1;
        for (int i = 0; i < N; i++) begin
            if (m_v[i] && m_key[i] == k) begin
                if (wr ? m_wr[i] : m_rd[i]) exp = {1'b1, 1'b0, 1'b0, m_ppn[i], off};
                else                        exp = {1'b0, 1'b0, 1'b1, 24'h0};
            end
        end
        check(req, {lk_hit, lk_miss, lk_fault, lk_paddr}, exp);
        lk_valid = 1'b0;
    endtask

    // Fill tag t; with_flush drives flush in the same cycle.
    task automatic fill(int t, int salt, bit rd, bit wr, bit with_flush);
        logic [11:0] k = 12'(t);
        int slot = -1;
        @(negedge clk);
        fl_valid = 1'b1; fl_seg = k[3:0]; fl_vpn = k[11:4];
        fl_ppn = ppn_of(t, salt); fl_rd = rd; fl_wr = wr; flush = with_flush;
        @(negedge clk);
        fl_valid = 1'b0; flush = 1'b0;
        if (with_flush) begin
            for (int i = 0; i < N; i++) m_v[i] = 1'b0;
        end else begin
            for (int i = 0; i < N; i++) if (m_v[i] && m_key[i] == k) slot = i;
            if (slot < 0) begin
                for (int i = N - 1; i >= 0; i--) if (!m_v[i]) slot = i;
                if (slot < 0) slot = m_ptr;
                m_ptr = (m_ptr + 1) % N;
            end
            m_v[slot] = 1'b1; m_key[slot] = k; m_ppn[slot] = ppn_of(t, salt);
            m_rd[slot] = rd; m_wr[slot] = wr;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) m_v[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: idle with a key present
        lk_seg = 4'h3; lk_vpn = 8'h1;
        #1 check("R10", {lk_hit, lk_miss, lk_fault, lk_paddr}, '0);
        // R9: empty after reset
        look(0, 1'b0, "R9");
        look(77, 1'b1, "R9");
        // R3: miss, fill, then hit
        fill(0, 0, 1'b1, 1'b0, 1'b0);
        look(0, 1'b0, "R3");
        look(0, 1'b1, "R7");
        // fill the rest; write permission withheld on every third tag
        for (int t = 1; t < N; t++) fill(t, 0, 1'b1, (t % 3) != 0, 1'b0);
        for (int t = 0; t < N; t++) begin
            look(t, 1'b0, "R2");
            look(t, 1'b1, "R7");
        end
        // R1: same vpn, other segment
        look(16 * 2 + 9, 1'b0, "R1");
        look(16 * 200 + 2, 1'b0, "R1");
        // R5: full buffer, pointer at 0
        fill(100, 0, 1'b1, 1'b1, 1'b0);
        look(0, 1'b0, "R5");
        look(1, 1'b0, "R5");
        look(100, 1'b0, "R5");
        // R6: rewrite tag 5 in place, read revoked
        fill(5, 9, 1'b0, 1'b1, 1'b0);
        look(5, 1'b0, "R6");
        look(5, 1'b1, "R6");
        fill(101, 0, 1'b1, 1'b1, 1'b0);
        look(1, 1'b0, "R6");
        look(2, 1'b0, "R6");
        look(5, 1'b1, "R6");
        // R8: flush with a concurrent fill
        fill(200, 0, 1'b1, 1'b1, 1'b1);
        look(200, 1'b0, "R8");
        for (int t = 0; t < N; t++) look(t, 1'b0, "R8");
        // R4: refill from empty, then pointer resumes
        for (int t = 300; t < 300 + N; t++) fill(t, 1, 1'b1, 1'b1, 1'b0);
        for (int t = 300; t < 300 + N; t++) look(t, 1'b1, "R4");
        fill(400, 0, 1'b1, 1'b1, 1'b0);
        look(300, 1'b0, "R4");
        look(301, 1'b0, "R5");
        look(302, 1'b0, "R5");
        look(400, 1'b0, "R5");
        // overflow sweep across many tags
        for (int t = 500; t < 600; t++) fill(t, 2, (t % 2) == 0, (t % 5) != 0, 1'b0);
        for (int t = 280; t < 620; t++) look(t, (t % 3) == 0, "R5");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule